// File: doc/BRIEF.md
# Memory Operand Address Generator for a 16-bit Segmented Processor

This unit decodes the addressing byte that follows an opcode in a 16-bit segmented instruction set. It takes the addressing byte, the two bytes that may follow it, the operand width, and the current values of the data and stack segment registers and the four address registers (BX, BP, SI, DI). When the operand lives in memory, it forms the 16-bit offset and the 20-bit physical address. When the operand is a register, it returns the register-file selector instead. In both cases it also reports how many bytes the addressing byte and its displacement take, so the fetch logic can advance the instruction pointer.

The addressing byte is read as three fields: mode in bits [7:6], a register field in bits [5:3] that this unit ignores, and the r/m field in bits [2:0]. The displacement arrives as a low byte and a high byte. A one-byte displacement uses only the low byte.

Decoding is combinational. The result is captured in output registers one clock after an input strobe and is marked by a valid pulse, so one decode can be issued each cycle.

Top module: `modrm_addr_gen`

## Requirements
- R1: While reset (`rst_n` low) is asserted and in the first cycle after it is released, `out_valid` is 0 and every result output is 0.
- R2: An input presented with `in_valid` high appears on the outputs with `out_valid` high exactly one clock later. A cycle with `in_valid` low drives `out_valid` low on the next clock, and the result outputs keep their previous values.
- R3: `field_len` is 2 for mode 00 (except the direct case), 3 for mode 01, 4 for mode 10, 4 for the direct case, and 2 for mode 11.
- R4: In memory modes, r/m 000/001/010/011 give BX+SI, BX+DI, BP+SI, BP+DI. r/m 100 gives SI, 101 gives DI, 110 gives BP and 111 gives BX. The displacement is added to this sum.
- R5: Mode 00 with r/m 110 is the direct case. The offset is the 16-bit displacement {hi, lo} alone, with no register added, and the data segment is used.
- R6: In mode 01 the low displacement byte is sign-extended to 16 bits before it is added. The high byte is ignored.
- R7: The offset wraps modulo 2^16. The physical address is (segment << 4) + offset, wrapped modulo 2^20.
- R8: `use_ss` is 1, and the stack segment is used, when BP is the base: r/m 010 or 011 in any memory mode, or r/m 110 in mode 01 or 10. In every other memory case the data segment is used and `use_ss` is 0.
- R9: Mode 11 with a word operand sets `is_reg`, `reg_hi` is 0, and `reg_idx` = r/m, where 0..7 name AX, CX, DX, BX, SP, BP, SI, DI.
- R10: Mode 11 with a byte operand sets `is_reg`, `reg_idx` = {0, r/m[1:0]} (A, C, D, B), and `reg_hi` = r/m[2] (1 selects the high byte).
- R11: For a register operand, `offset` and `phys_addr` are 0 and `use_ss` is 0. For a memory operand, `is_reg`, `reg_idx` and `reg_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode request strobe |
| modrm | input | 8 | Addressing byte: mode [7:6], register [5:3], r/m [2:0] |
| disp_lo | input | 8 | First byte after the addressing byte |
| disp_hi | input | 8 | Second byte after the addressing byte |
| word_op | input | 1 | 1 = word operand, 0 = byte operand |
| seg_data | input | 16 | Data segment register value |
| seg_stack | input | 16 | Stack segment register value |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| is_reg | output | 1 | Operand is a register |
| reg_idx | output | 3 | Register-file selector |
| reg_hi | output | 1 | Byte operand is the high half |
| field_len | output | 3 | Bytes taken by the addressing byte and displacement |
| use_ss | output | 1 | Stack segment chosen as the default |
| offset | output | 16 | 16-bit effective offset |
| phys_addr | output | 20 | 20-bit physical address |

## Verification
The bench targets the direct-address exception with a nonzero register field.

| Corner case | What a design that got it wrong would do |
|---|---|
| Direct-address exception | Treats the case as BP-based: adds BP, picks the stack segment, or reports 2 bytes. |
| Negative one-byte displacements (0x80 and 0xF0) | Without sign extension, lands 256 bytes too high. |
| Byte register with r/m bit 2 set | Returns a word index (SP/BP/SI/DI) instead of a high half. |
| Offset wrap at 2^16 | Leaks a carry into bit 16. |
| Physical address wrap at 2^20 (segment 0xFFFF) | Leaks a carry into bit 20. |
| Hold behaviour | Lets outputs follow new inputs while no request is pending. |

// File: rtl/modrm_addr_gen.sv
module modrm_addr_gen #(
  parameter int OFS_W = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [7:0]                 modrm,
  input  logic [7:0]                 disp_lo,
  input  logic [7:0]                 disp_hi,
  input  logic                       word_op,
  input  logic [OFS_W-1:0]           seg_data,
  input  logic [OFS_W-1:0]           seg_stack,
  input  logic [OFS_W-1:0]           reg_bx,
  input  logic [OFS_W-1:0]           reg_bp,
  input  logic [OFS_W-1:0]           reg_si,
  input  logic [OFS_W-1:0]           reg_di,
  output logic                       out_valid,
  output logic                       is_reg,
  output logic [2:0]                 reg_idx,
  output logic                       reg_hi,
  output logic [2:0]                 field_len,
  output logic                       use_ss,
  output logic [OFS_W-1:0]           offset,
  output logic [OFS_W+SEG_SHIFT-1:0] phys_addr
);
  localparam int PA_W = OFS_W + SEG_SHIFT;

  logic [1:0] mode;
  logic [2:0] rm;
  logic       direct, reg_op, bp_base;
  logic [OFS_W-1:0] disp_w, disp_b, disp_v, base_v, index_v, ofs_c;
  logic [PA_W-1:0]  seg_base, pa_c;
  logic [2:0] len_c, idx_c;
  logic       hi_c, ss_c;

  assign mode    = modrm[7:6];
  assign rm      = modrm[2:0];
  assign reg_op  = (mode == 2'b11);
  assign direct  = (mode == 2'b00) && (rm == 3'b110);
  assign disp_w  = OFS_W'({disp_hi, disp_lo});
  assign disp_b  = OFS_W'($signed(disp_lo));
  assign disp_v  = (direct || mode == 2'b10) ? disp_w :
                   (mode == 2'b01) ? disp_b : '0;
  assign bp_base = (rm == 3'b010) || (rm == 3'b011) || (rm == 3'b110 && !direct);

  always_comb begin
    case (rm)
      3'b000, 3'b001, 3'b111: base_v = reg_bx;
      3'b010, 3'b011:         base_v = reg_bp;
      3'b110:                 base_v = direct ? '0 : reg_bp;
      default:                base_v = '0;
    endcase
    case (rm)
      3'b000, 3'b010, 3'b100: index_v = reg_si;
      3'b001, 3'b011, 3'b101: index_v = reg_di;
      default:                index_v = '0;
    endcase
  end

  assign ofs_c    = base_v + index_v + disp_v;
  assign ss_c     = !reg_op && bp_base;
  assign seg_base = {(ss_c ? seg_stack : seg_data), {SEG_SHIFT{1'b0}}};
  assign pa_c     = seg_base + PA_W'(ofs_c);
  assign len_c    = reg_op ? 3'd2 : direct ? 3'd4 :
                    (mode == 2'b01) ? 3'd3 : (mode == 2'b10) ? 3'd4 : 3'd2;
  assign idx_c    = !reg_op ? 3'd0 : word_op ? rm : {1'b0, rm[1:0]};
  assign hi_c     = reg_op && !word_op && rm[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      is_reg    <= 1'b0;
      reg_idx   <= '0;
      reg_hi    <= 1'b0;
      field_len <= '0;
      use_ss    <= 1'b0;
      offset    <= '0;
      phys_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_reg    <= reg_op;
        reg_idx   <= idx_c;
        reg_hi    <= hi_c;
        field_len <= len_c;
        use_ss    <= ss_c;
        offset    <= reg_op ? '0 : ofs_c;
        phys_addr <= reg_op ? '0 : pa_c;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(phys_addr) && $stable(field_len)); // R2
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> field_len >= 3'd2 && field_len <= 3'd4); // R3
  AST_REG_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_reg |-> phys_addr == '0 && offset == '0 && !use_ss && field_len == 3'd2); // R11
  AST_HI_ONLY_REG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && reg_hi |-> is_reg && !reg_idx[2]); // R10
  AST_MEM_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !is_reg |-> reg_idx == 3'd0 && !reg_hi); // R11
endmodule

// File: tb/modrm_addr_gen_bench.sv
module modrm_addr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] modrm = '0, disp_lo = '0, disp_hi = '0;
  logic word_op = 1'b1;
  logic [15:0] seg_data = 16'h1234, seg_stack = 16'h5000;
  logic [15:0] reg_bx = 16'h1000, reg_bp = 16'h2000, reg_si = 16'h0030, reg_di = 16'h0400;
  logic out_valid, is_reg, reg_hi, use_ss;
  logic [2:0] reg_idx, field_len;
  logic [15:0] offset;
  logic [19:0] phys_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  modrm_addr_gen u_modrm_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm(modrm),
    .disp_lo(disp_lo), .disp_hi(disp_hi), .word_op(word_op),
    .seg_data(seg_data), .seg_stack(seg_stack), .reg_bx(reg_bx),
    .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .out_valid(out_valid), .is_reg(is_reg), .reg_idx(reg_idx),
    .reg_hi(reg_hi), .field_len(field_len), .use_ss(use_ss),
    .offset(offset), .phys_addr(phys_addr));

  // modrm, disp{hi,lo}, word, is_reg, idx, hi, len, ss, offset, phys
  localparam int NV = 13;
  localparam logic [69:0] VEC [NV] = '{
    {8'h00, 16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 3'd2, 1'b0, 16'h1030, 20'h13370}, // R4 BX+SI
    {8'h03, 16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 3'd2, 1'b1, 16'h2400, 20'h52400}, // R4 R8 BP+DI
    {8'h06, 16'h5678, 1'b1, 1'b0, 3'd0, 1'b0, 3'd4, 1'b0, 16'h5678, 20'h179B8}, // R5 direct
    {8'h46, 16'hAA10, 1'b1, 1'b0, 3'd0, 1'b0, 3'd3, 1'b1, 16'h2010, 20'h52010}, // R8 BP+d8
    {8'h44, 16'h00F0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd3, 1'b0, 16'h0020, 20'h12360}, // R6 SI-16
    {8'h87, 16'h0100, 1'b1, 1'b0, 3'd0, 1'b0, 3'd4, 1'b0, 16'h1100, 20'h13440}, // R3 BX+d16
    {8'h85, 16'h1234, 1'b0, 1'b0, 3'd0, 1'b0, 3'd4, 1'b0, 16'h1634, 20'h13974}, // R4 DI+d16
    {8'h42, 16'h007F, 1'b1, 1'b0, 3'd0, 1'b0, 3'd3, 1'b1, 16'h20AF, 20'h520AF}, // R4 BP+SI+d8
    {8'h41, 16'h0080, 1'b1, 1'b0, 3'd0, 1'b0, 3'd3, 1'b0, 16'h1380, 20'h136C0}, // R6 BX+DI-128
    {8'hC5, 16'hFFFF, 1'b1, 1'b1, 3'd5, 1'b0, 3'd2, 1'b0, 16'h0000, 20'h00000}, // R9 BP reg
    {8'hC5, 16'hFFFF, 1'b0, 1'b1, 3'd1, 1'b1, 3'd2, 1'b0, 16'h0000, 20'h00000}, // R10 CH
    {8'hC3, 16'h0000, 1'b0, 1'b1, 3'd3, 1'b0, 3'd2, 1'b0, 16'h0000, 20'h00000}, // R10 BL
    {8'h3E, 16'hFFFF, 1'b1, 1'b0, 3'd0, 1'b0, 3'd4, 1'b0, 16'hFFFF, 20'h2233F}  // R5 direct, reg field set
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] m, input logic [15:0] d, input logic w);
    @(negedge clk);
    modrm = m; disp_lo = d[7:0]; disp_hi = d[15:8]; word_op = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, out_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, out_valid}, 0);
        chk("R1 phys after reset", {12'd0, phys_addr}, 0);
        chk("R1 len after reset", {29'd0, field_len}, 0);

        for (int i = 0; i < NV; i++) begin
          issue(VEC[i][69:62], VEC[i][61:46], VEC[i][45]);
          chk($sformatf("R2 valid v%0d", i), {31'd0, out_valid}, 1);
          chk($sformatf("R9/R10/R11 is_reg v%0d", i), {31'd0, is_reg}, {31'd0, VEC[i][44]});
          chk($sformatf("R9/R10 reg_idx v%0d", i), {29'd0, reg_idx}, {29'd0, VEC[i][43:41]});
          chk($sformatf("R10 reg_hi v%0d", i), {31'd0, reg_hi}, {31'd0, VEC[i][40]});
          chk($sformatf("R3 field_len v%0d", i), {29'd0, field_len}, {29'd0, VEC[i][39:37]});
          chk($sformatf("R8 use_ss v%0d", i), {31'd0, use_ss}, {31'd0, VEC[i][36]});
          chk($sformatf("R4/R5/R6 offset v%0d", i), {16'd0, offset}, {16'd0, VEC[i][35:20]});
          chk($sformatf("R7 phys v%0d", i), {12'd0, phys_addr}, {12'd0, VEC[i][19:0]});
        end

        // R2 hold: no request, new inputs, outputs must not move
        @(negedge clk);
        modrm = 8'h00; disp_lo = 8'h55;
        @(negedge clk);
        chk("R2 idle valid", {31'd0, out_valid}, 0);
        chk("R2 idle hold phys", {12'd0, phys_addr}, 32'h2233F);
        chk("R2 idle hold len", {29'd0, field_len}, 4);

        // R7 offset and physical wrap
        reg_bx = 16'hFFF0; reg_si = 16'h0020; seg_data = 16'hFFFF;
        issue(8'h00, 16'h0000, 1'b1);
        chk("R7 offset wrap", {16'd0, offset}, 32'h0010);
        chk("R7 phys wrap", {12'd0, phys_addr}, 32'h00000);

        reg_bp = 16'hFFFF; seg_stack = 16'hF000;
        issue(8'h86, 16'h0002, 1'b1);
        chk("R7 BP+d16 wrap offset", {16'd0, offset}, 32'h0001);
        chk("R8 BP+d16 ss", {31'd0, use_ss}, 1);
        chk("R7 BP+d16 phys", {12'd0, phys_addr}, 32'hF0001);

        // R5: direct case ignores BP even when BP is nonzero
        issue(8'h06, 16'h0000, 1'b1);
        chk("R5 direct offset", {16'd0, offset}, 0);
        chk("R5 direct uses data seg", {31'd0, use_ss}, 0);
        chk("R5 direct phys", {12'd0, phys_addr}, 32'hFFFF0);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears offset", {16'd0, offset}, 0);
        chk("R1 reset clears valid", {31'd0, out_valid}, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule